// File: doc/BRIEF.md
# LED Dimmer Register Slave with Auto-Increment

This block is the serial-bus front end of a two-channel LED dimmer. It watches SCL and SDA, which arrive already synchronised to the system clock. It recognises its own device address, where the lowest address bit comes from a strap pin. It acknowledges each byte it receives by pulling SDA low. The first byte of a write is a command byte. That byte sets a register pointer and an auto-increment flag, and any following data bytes go into a small register bank. The bank feeds the PWM logic beside this block. It holds a prescaler and a duty value for each of two blink channels, plus an LED source selector.

A read begins with a write of the command byte. The master then issues a repeated START and sends the address with the read bit set. The slave then shifts register contents out MSB first. The master acknowledges every byte except the last one. Register 0 is read-only and returns the current level of the two LED pins, sampled again for every byte sent. When auto-increment is set, the pointer steps after each data byte and wraps from the selector back to register 0. When the flag is clear, the pointer stays where it is.

Top module: `ledreg_i2c_slave`

## Requirements
- R1: The slave acknowledges only the address byte whose upper seven bits equal binary 110000 followed by strap_i. Bit 0 is R/W, with 1 meaning read. Any other address gets no acknowledge, and SDA stays released until the next START.
- R2: In a write, the byte after the address is the command byte. Bits [2:0] are the register pointer and bit 4 is the auto-increment flag. Each later data byte is stored at the current pointer.
- R3: The pointer codes are 0 = pin levels, 1 = prescaler of channel 0, 2 = duty of channel 0, 3 = prescaler of channel 1, 4 = duty of channel 1, 5 = selector. The selector stores 4 bits and reads back with bits [7:4] equal to 1111. Channel 0 appears in bits [7:0] of presc_o and duty_o, and channel 1 in bits [15:8].
- R4: With auto-increment set, the pointer advances after every data byte, whether written or read. After pointer 5 it wraps to 0.
- R5: A data byte written to pointer 0, 6 or 7 is acknowledged but changes no register. Pointers 6 and 7 read as 00h.
- R6: Pointer 0 reads {6'b0, pin_lvl_i}. The pins are sampled when each byte is loaded for sending, so every byte sees the current levels.
- R7: While rst_ni is low, and after it is released, the prescalers are 00h, the duty registers are 80h, the selector is 0 and the command register is 00h. A read with no command byte first therefore returns the pin levels.
- R8: A read shifts the byte out MSB first, one bit per SCL low phase. After the master's NACK the slave releases SDA, so the master can send STOP.
- R9: With auto-increment clear, the pointer does not move, so consecutive read bytes return the same register.
- R10: For every address match, command byte and data byte it receives, the slave holds SDA low through the whole high phase of the ninth clock.
- R11: A STOP at any point returns the slave to idle. A byte cut short by a STOP is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_pull_o | output | 1 | When high, the pad pulls SDA low |
| strap_i | input | 1 | Lowest bit of the device address |
| pin_lvl_i | input | 2 | Current levels of the two LED pins |
| presc_o | output | 16 | Prescalers: channel 0 in [7:0], channel 1 in [15:8] |
| duty_o | output | 16 | Duty values: channel 0 in [7:0], channel 1 in [15:8] |
| sel_o | output | 4 | LED source selector, 2 bits per pin |

## Verification
The assertions take three things for granted about the bus inputs. Every SCL and SDA level lasts at least two clocks. SDA changes only while SCL is low, except to form a START or a STOP. While the slave transmits, the master leaves SDA released except during its acknowledge bit. The bench models the bus as a wired-AND of the master's drive and the slave's pull-down. It holds every phase for three or more clocks and moves SDA only in the SCL low phase, outside the deliberate START and STOP conditions. Because of that, every edge the slave sees is a clean, single-cycle event.

// File: rtl/ledreg_pkg.sv
package ledreg_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 3;
  localparam int AI_BIT = 4;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} bus_st_e;
  typedef enum logic [1:0] {K_ADDR, K_CMD, K_DATA} byte_kind_e;

  localparam logic [PTR_W-1:0] P_PINS = '0;
endpackage

// File: rtl/ledreg_busdet.sv
module ledreg_busdet (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA moving while SCL stays high
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/ledreg_bank.sv
module ledreg_bank import ledreg_pkg::*; #(
  parameter int             NUM_CH   = 2,
  parameter int             NUM_PINS = 2,
  parameter logic [BYTE_W-1:0] DUTY_RST = 8'h80,
  localparam int            SEL_W    = 2 * NUM_PINS,
  localparam int            LAST_PTR = 2 * NUM_CH + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [PTR_W-1:0]         ptr_i,
  input  logic [BYTE_W-1:0]        wr_data_i,
  input  logic [NUM_PINS-1:0]      pin_lvl_i,
  output logic [BYTE_W-1:0]        rd_data_o,
  output logic [NUM_CH*BYTE_W-1:0] presc_o,
  output logic [NUM_CH*BYTE_W-1:0] duty_o,
  output logic [SEL_W-1:0]         sel_o
);
  localparam logic [PTR_W-1:0] SEL_PTR = PTR_W'(LAST_PTR);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [PTR_W-1:0] PSC_PTR = PTR_W'(2 * ch + 1);
    localparam logic [PTR_W-1:0] DTY_PTR = PTR_W'(2 * ch + 2);
    logic [BYTE_W-1:0] psc_q, dty_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        psc_q <= '0;
        dty_q <= DUTY_RST;
      end else if (wr_en_i) begin
        if (ptr_i == PSC_PTR) psc_q <= wr_data_i;
        if (ptr_i == DTY_PTR) dty_q <= wr_data_i;
      end
    end

    assign presc_o[ch*BYTE_W +: BYTE_W] = psc_q;
    assign duty_o[ch*BYTE_W +: BYTE_W]  = dty_q;
  end

  logic [SEL_W-1:0] sel_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           sel_q <= '0;
    else if (wr_en_i && ptr_i == SEL_PTR)  sel_q <= wr_data_i[SEL_W-1:0];
  end
  assign sel_o = sel_q;

  always_comb begin
    rd_data_o = '0;
    if (ptr_i == P_PINS) rd_data_o[NUM_PINS-1:0] = pin_lvl_i;
    else if (ptr_i == SEL_PTR) rd_data_o = {{(BYTE_W-SEL_W){1'b1}}, sel_q};
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (ptr_i == PTR_W'(2 * ch + 1)) rd_data_o = presc_o[ch*BYTE_W +: BYTE_W];
      if (ptr_i == PTR_W'(2 * ch + 2)) rd_data_o = duty_o[ch*BYTE_W +: BYTE_W];
    end
  end

  // R5: no write strobe, or a write to pin levels or unused codes, leaves the bank untouched
  assert_bank_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || ptr_i == P_PINS || ptr_i > SEL_PTR)
      |=> ($stable(presc_o) && $stable(duty_o) && $stable(sel_o)));
endmodule

// File: rtl/ledreg_i2c_slave.sv
module ledreg_i2c_slave import ledreg_pkg::*; #(
  parameter logic [5:0]        DEV_ID   = 6'b110000,
  parameter int                NUM_CH   = 2,
  parameter int                NUM_PINS = 2,
  parameter logic [BYTE_W-1:0] DUTY_RST = 8'h80
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_pull_o,
  input  logic                     strap_i,
  input  logic [NUM_PINS-1:0]      pin_lvl_i,
  output logic [NUM_CH*BYTE_W-1:0] presc_o,
  output logic [NUM_CH*BYTE_W-1:0] duty_o,
  output logic [2*NUM_PINS-1:0]    sel_o
);
  localparam int               LAST_PTR = 2 * NUM_CH + 1;
  localparam logic [PTR_W-1:0] WRAP_PTR = PTR_W'(LAST_PTR);

  logic scl_rise, scl_fall, start_det, stop_det;

  ledreg_busdet i_busdet (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  bus_st_e           state_q;
  byte_kind_e        kind_q;
  logic [2:0]        bit_q;
  logic              full_q, rw_q, mack_q;
  logic [BYTE_W-1:0] shreg_q, tx_q, rd_data;
  logic [PTR_W-1:0]  ptr_q, ptr_nxt;
  logic              ai_q;

  logic rx_done, wr_en, cmd_ld, tx_ld, ptr_adv, addr_hit;

  assign addr_hit = (shreg_q[7:1] == {DEV_ID, strap_i});
  assign rx_done  = (state_q == ST_RX) && scl_fall && full_q;
  assign wr_en    = rx_done && (kind_q == K_DATA);
  assign cmd_ld   = rx_done && (kind_q == K_CMD);
  assign tx_ld    = scl_fall &&
                    (((state_q == ST_ACK) && (kind_q == K_ADDR) && rw_q) ||
                     ((state_q == ST_MACK) && mack_q));
  assign ptr_adv  = ai_q && (wr_en || tx_ld);
  assign ptr_nxt  = (ptr_q == WRAP_PTR) ? '0 : ptr_q + 1'b1;

  ledreg_bank #(
    .NUM_CH  (NUM_CH),
    .NUM_PINS(NUM_PINS),
    .DUTY_RST(DUTY_RST)
  ) i_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .ptr_i    (ptr_q),
    .wr_data_i(shreg_q),
    .pin_lvl_i(pin_lvl_i),
    .rd_data_o(rd_data),
    .presc_o  (presc_o),
    .duty_o   (duty_o),
    .sel_o    (sel_o)
  );

  // command register: pointer plus auto-increment flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      ai_q  <= 1'b0;
    end else if (cmd_ld) begin
      ptr_q <= shreg_q[PTR_W-1:0];
      ai_q  <= shreg_q[AI_BIT];
    end else if (ptr_adv) begin
      ptr_q <= ptr_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= K_ADDR;
      bit_q   <= '0;
      full_q  <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      shreg_q <= '0;
      tx_q    <= '0;
    end else if (start_det) begin
      state_q <= ST_RX;
      kind_q  <= K_ADDR;
      bit_q   <= '0;
      full_q  <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      full_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
            bit_q   <= bit_q + 3'd1;
            if (bit_q == 3'd7) full_q <= 1'b1;
          end else if (rx_done) begin
            full_q <= 1'b0;
            if (kind_q != K_ADDR) state_q <= ST_ACK;
            else if (addr_hit) begin
              rw_q    <= shreg_q[0];
              state_q <= ST_ACK;
            end else state_q <= ST_IDLE;
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (kind_q == K_ADDR && rw_q) begin
              tx_q    <= rd_data;
              bit_q   <= '0;
              state_q <= ST_TX;
            end else begin
              kind_q  <= (kind_q == K_ADDR) ? K_CMD : K_DATA;
              state_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            tx_q  <= {tx_q[BYTE_W-2:0], 1'b1};
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) state_q <= ST_MACK;
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_q <= ~sda_i;
          else if (scl_fall) begin
            if (mack_q) begin
              tx_q    <= rd_data;
              state_q <= ST_TX;
            end else state_q <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = (state_q == ST_ACK) || ((state_q == ST_TX) && !tx_q[BYTE_W-1]);

  assert_stop_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state_q == ST_IDLE));

  assert_start_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (state_q == ST_RX && kind_q == K_ADDR && bit_q == 3'd0 && !full_q));

  assert_ack_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && !scl_fall && !start_det && !stop_det) |=> sda_pull_o);

  assert_ptr_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_adv && ptr_q == WRAP_PTR) |=> (ptr_q == '0));

  assert_ptr_fixed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ai_q && !cmd_ld) |=> $stable(ptr_q));
endmodule

// File: tb/test_ledreg_i2c_slave.sv
module test_ledreg_i2c_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic [1:0] pins = 2'b10;
  logic sda_pull;
  logic [15:0] presc, duty;
  logic [3:0] sel;
  wire sda_line = sda_m & ~sda_pull;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ledreg_i2c_slave i_ledreg_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .strap_i(strap), .pin_lvl_i(pins),
    .presc_o(presc), .duty_o(duty), .sel_o(sel)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(3); scl = 1'b1; tick(3);
    sda_m = 1'b0; tick(3); scl = 1'b0; tick(3);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(3); scl = 1'b1; tick(3);
    sda_m = 1'b1; tick(3);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(3); scl = 1'b1; tick(3); scl = 1'b0; tick(3);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; tick(3); scl = 1'b1; tick(1);
    a1 = ~sda_line; tick(3);
    a2 = ~sda_line; scl = 1'b0; tick(3);
    ack = a1 & a2;
  endtask

  task automatic send_acked(input logic [7:0] b, input string req);
    logic ack;
    send_byte(b, ack);
    expect_eq(req, ack, 1'b1);
  endtask

  task automatic get_bits(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(3); scl = 1'b1; tick(2);
      d[i] = sda_line; tick(2); scl = 1'b0; tick(3);
    end
  endtask

  task automatic m_ack(input logic ack);
    sda_m = ~ack; tick(3); scl = 1'b1; tick(3); scl = 1'b0; tick(2);
    sda_m = 1'b1; tick(2);
  endtask

  task automatic set_ptr(input logic [7:0] cmd, input logic [7:0] addr_w);
    bus_start();
    send_acked(addr_w, "R10 addr ack");
    send_acked(cmd, "R10 cmd ack");
  endtask

  task automatic t_reset();
    expect_eq("R7 presc reset", presc, 16'h0000);
    expect_eq("R7 duty reset", duty, 16'h8080);
    expect_eq("R7 sel reset", sel, 4'h0);
    expect_eq("R7 sda released", sda_pull, 1'b0);
  endtask

  task automatic t_read_default();
    logic [7:0] d;
    bus_start();
    send_acked(8'hC1, "R8 read addr ack");
    get_bits(d);
    m_ack(1'b0);
    expect_eq("R7 R6 default ptr reads pins", d, 8'h02);
    expect_eq("R8 released after nack", sda_pull, 1'b0);
    bus_stop();
  endtask

  task automatic t_wrong_addr();
    logic ack;
    bus_start();
    send_byte(8'hC2, ack);
    expect_eq("R1 strap mismatch no ack", ack, 1'b0);
    put_bit(1'b0);
    expect_eq("R1 stays released", sda_pull, 1'b0);
    bus_stop();
    bus_start();
    send_byte(8'h90, ack);
    expect_eq("R1 foreign addr no ack", ack, 1'b0);
    bus_stop();
    expect_eq("R1 no register change", presc, 16'h0000);
  endtask

  task automatic t_write_ai();
    set_ptr(8'h11, 8'hC0);
    send_acked(8'h97, "R10 data ack");
    send_acked(8'h55, "R10 data ack");
    send_acked(8'h03, "R10 data ack");
    send_acked(8'h40, "R10 data ack");
    send_acked(8'h0E, "R10 data ack");
    bus_stop();
    expect_eq("R2 R3 R4 presc", presc, 16'h0397);
    expect_eq("R3 R4 duty", duty, 16'h4055);
    expect_eq("R3 R4 sel", sel, 4'hE);
  endtask

  task automatic t_wrap();
    set_ptr(8'h15, 8'hC0);
    send_acked(8'h09, "R4 sel write ack");
    send_acked(8'hAA, "R5 pin reg write ack");
    send_acked(8'h33, "R4 wrapped write ack");
    bus_stop();
    expect_eq("R4 sel", sel, 4'h9);
    expect_eq("R4 R5 wrap to presc0, pin reg ignored", presc, 16'h0333);
    expect_eq("R5 duty untouched", duty, 16'h4055);
  endtask

  task automatic t_read_ai();
    logic [7:0] d;
    logic [7:0] exp [5] = '{8'h33, 8'h55, 8'h03, 8'h40, 8'hF9};
    set_ptr(8'h11, 8'hC0);
    bus_start();
    send_acked(8'hC1, "R8 rstart addr ack");
    for (int i = 0; i < 5; i++) begin
      get_bits(d);
      m_ack(i != 4);
      expect_eq("R4 R3 R8 auto-inc read", d, exp[i]);
    end
    expect_eq("R8 released after nack", sda_pull, 1'b0);
    bus_stop();
  endtask

  task automatic t_read_fixed();
    logic [7:0] d;
    set_ptr(8'h02, 8'hC0);
    bus_start();
    send_acked(8'hC1, "R9 addr ack");
    for (int i = 0; i < 3; i++) begin
      get_bits(d);
      m_ack(i != 2);
      expect_eq("R9 fixed pointer read", d, 8'h55);
    end
    bus_stop();
    set_ptr(8'h00, 8'hC0);
    bus_start();
    send_acked(8'hC1, "R6 addr ack");
    get_bits(d);
    expect_eq("R6 pins first byte", d, 8'h02);
    pins = 2'b01;
    m_ack(1'b1);
    get_bits(d);
    m_ack(1'b0);
    expect_eq("R6 pins resampled", d, 8'h01);
    bus_stop();
  endtask

  task automatic t_ptr67();
    logic [7:0] d;
    set_ptr(8'h06, 8'hC0);
    send_acked(8'h77, "R5 ptr6 write ack");
    bus_stop();
    expect_eq("R5 ptr6 presc", presc, 16'h0333);
    expect_eq("R5 ptr6 duty", duty, 16'h4055);
    expect_eq("R5 ptr6 sel", sel, 4'h9);
    set_ptr(8'h07, 8'hC0);
    bus_start();
    send_acked(8'hC1, "R5 addr ack");
    get_bits(d);
    m_ack(1'b0);
    expect_eq("R5 ptr7 reads zero", d, 8'h00);
    bus_stop();
  endtask

  task automatic t_stop_mid();
    set_ptr(8'h01, 8'hC0);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    expect_eq("R11 partial byte dropped", presc, 16'h0333);
    expect_eq("R11 idle after stop", sda_pull, 1'b0);
    set_ptr(8'h01, 8'hC0);
    send_acked(8'h12, "R11 next write ack");
    bus_stop();
    expect_eq("R11 next write lands", presc, 16'h0312);
  endtask

  task automatic t_strap();
    logic ack;
    strap = 1'b1;
    tick(2);
    bus_start();
    send_byte(8'hC0, ack);
    expect_eq("R1 old address ignored", ack, 1'b0);
    bus_stop();
    set_ptr(8'h03, 8'hC2);
    send_acked(8'h21, "R1 strap write ack");
    bus_stop();
    expect_eq("R1 strap write", presc, 16'h2112);
  endtask

  task automatic t_reset_mid();
    logic [7:0] d;
    set_ptr(8'h04, 8'hC2);
    put_bit(1'b0);
    rst_n = 1'b0;
    tick(2);
    t_reset();
    sda_m = 1'b1; scl = 1'b1;
    tick(2);
    rst_n = 1'b1;
    tick(3);
    pins = 2'b11;
    bus_start();
    send_acked(8'hC3, "R7 addr ack after reset");
    get_bits(d);
    m_ack(1'b0);
    expect_eq("R7 command reset to pin reg", d, 8'h03);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(4);
    t_reset();
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_read_default();
    t_wrong_addr();
    t_write_ai();
    t_wrap();
    t_read_ai();
    t_read_fixed();
    t_ptr67();
    t_stop_mid();
    t_strap();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule